// File: doc/BRIEF.md
# ADC Register Front End

This block is the register-level front end for an eight-channel, ten-bit successive-approximation converter core. It sits on a simple 32-bit memory-mapped bus with byte offsets, a write enable and combinational read data. It holds the control word (channel select, start request, single-shot mode), the power switch for the core, the conversion-complete flag, the conversion result and a readback of the channel that was actually sampled. Toward the core it drives a channel select, a one-cycle start strobe and a power enable. The core returns a one-cycle done strobe together with its result.

Software powers the core up and writes a start request. The block holds that request until the core has been powered for a settling interval, then launches the conversion. When the core reports done, the block stores the result and the launched channel and raises the completion flag. Software then polls that flag and reads the result. Removing power at any point abandons the conversion and forgets any request that has not yet been launched.

Top module: `adc_regfront`

## Requirements
- R1: After reset every mapped register reads zero, and core_pwr and core_start are low.
- R2: The control word sits at offset 0x00: bits [2:0] are the channel, bit 4 requests a start, and bit 5 is the single-shot mode flag. It reads back channel and mode, with bit 4 showing a start that is still pending. Other bits read zero. A write with bit 4 clear does not cancel a pending start.
- R3: The power register at offset 0x10, bit 0, drives core_pwr and reads back the value written.
- R4: core_start is never raised until SETTLE_CYCLES clock edges (default 8) have passed since the power write. A pending start fires with core_start high in the cycle after edge SETTLE_CYCLES+1, counted from the power write edge.
- R5: Each launch is a single-cycle core_start pulse with core_sel carrying the requested channel. The start bit at offset 0x00 reads zero once the conversion is launched.
- R6: Writing a start clears the completion flag (offset 0x08, bit 0). A core done strobe during a conversion sets the flag and stores core_data in offset 0x04 bits [9:0], with bits [31:10] reading zero.
- R7: Offset 0x0C bits [2:0] return the channel captured at launch, even when the control word's channel is rewritten during the conversion.
- R8: Writing 0 to the power register lowers core_pwr, abandons a running conversion, clears the completion flag and any pending start, and restarts the settling count.
- R9: Offsets 0x14, 0x20 and every other unmapped offset read zero, and writes to them change no register and no core output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the bus and the converter core |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the access; bits [1:0] are ignored |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data for bus_addr, combinational |
| core_sel | output | CH_W | Channel select to the core |
| core_start | output | 1 | One-cycle conversion launch strobe |
| core_pwr | output | 1 | Power enable for the core |
| core_done | input | 1 | One-cycle completion strobe from the core |
| core_data | input | RES_W | Conversion result from the core, valid with core_done |

## Verification
The bench measures the exact cycle of the first launch after power-up, both on the first power-up and after a power-down. A design that counts too few cycles, or that does not restart the count on power-down, launches early and fails the check. It rewrites the channel during a running conversion and expects the sampled-channel register to keep the launched channel; a design that reports the live control field returns the new one. It removes power in mid-conversion and expects no completion flag, no new result and no pending start, then checks that a start written while the core is unpowered waits out a full settling interval. Writes of all-ones to unmapped offsets must leave the control and power registers untouched, which catches a loose address decode.

// File: rtl/adc_regfront_pkg.sv
package adc_regfront_pkg;

    // Word indices (byte offset / 4) of the mapped registers
    localparam int unsigned WIDX_CTRL    = 0;
    localparam int unsigned WIDX_RESULT  = 1;
    localparam int unsigned WIDX_DONE    = 2;
    localparam int unsigned WIDX_SAMPLED = 3;
    localparam int unsigned WIDX_POWER   = 4;

    // Bit positions inside the control word
    localparam int unsigned CTRL_START_BIT  = 4;
    localparam int unsigned CTRL_SINGLE_BIT = 5;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_CTRL,
        RSEL_RESULT,
        RSEL_DONE,
        RSEL_SAMPLED,
        RSEL_POWER
    } rsel_e;

    // Bus write events, decoded once and fanned out to the sequencer
    typedef struct packed {
        logic ctrl_wr;
        logic start_req;
        logic pwr_on_wr;
        logic pwr_off_wr;
    } wr_evt_t;

    function automatic rsel_e decode_word(input int unsigned widx);
        rsel_e sel;
        case (widx)
            WIDX_CTRL:    sel = RSEL_CTRL;
            WIDX_RESULT:  sel = RSEL_RESULT;
            WIDX_DONE:    sel = RSEL_DONE;
            WIDX_SAMPLED: sel = RSEL_SAMPLED;
            WIDX_POWER:   sel = RSEL_POWER;
            default:      sel = RSEL_NONE;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/adc_bus_port.sv
module adc_bus_port
    import adc_regfront_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned BUS_W  = 32,
    parameter int unsigned CH_W   = 3,
    parameter int unsigned RES_W  = 10
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output wr_evt_t           evt,
    output logic [CH_W-1:0]   wr_chan,
    output logic              wr_single,
    input  logic [CH_W-1:0]   ctrl_chan,
    input  logic              ctrl_single,
    input  logic              start_pend,
    input  logic [RES_W-1:0]  result,
    input  logic              conv_flag,
    input  logic [CH_W-1:0]   samp_chan,
    input  logic              pwr_on
);

    localparam int unsigned WIDX_W = ADDR_W - 2;

    rsel_e sel;
    logic  unused_bus_bits;

    assign sel = decode_word(32'(bus_addr[ADDR_W-1:2]));
    assign unused_bus_bits = ^{bus_wdata, bus_addr[1:0]};

    assign wr_chan   = bus_wdata[CH_W-1:0];
    assign wr_single = bus_wdata[CTRL_SINGLE_BIT];

    always_comb begin
        evt            = '0;
        evt.ctrl_wr    = bus_we && (sel == RSEL_CTRL);
        evt.start_req  = evt.ctrl_wr && bus_wdata[CTRL_START_BIT];
        evt.pwr_on_wr  = bus_we && (sel == RSEL_POWER) && bus_wdata[0];
        evt.pwr_off_wr = bus_we && (sel == RSEL_POWER) && !bus_wdata[0];
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            RSEL_CTRL: begin
                bus_rdata[CH_W-1:0]       = ctrl_chan;
                bus_rdata[CTRL_START_BIT]  = start_pend;
                bus_rdata[CTRL_SINGLE_BIT] = ctrl_single;
            end
            RSEL_RESULT:  bus_rdata[RES_W-1:0] = result;
            RSEL_DONE:    bus_rdata[0]         = conv_flag;
            RSEL_SAMPLED: bus_rdata[CH_W-1:0]  = samp_chan;
            RSEL_POWER:   bus_rdata[0]         = pwr_on;
            default:      bus_rdata            = '0;
        endcase
    end

    if (WIDX_W < 3) begin : g_addr_too_narrow
        // the power register needs word index 4
        initial $error("ADDR_W too small for the register map");
    end

endmodule

// File: rtl/adc_settle_timer.sv
module adc_settle_timer #(
    parameter int unsigned SETTLE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_on,
    output logic settled
);

    localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SETTLE_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !pwr_on) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign settled = pwr_on && (cnt_q == CNT_MAX);

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_regfront_pkg::*;
#(
    parameter int unsigned CH_W  = 3,
    parameter int unsigned RES_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_evt_t          evt,
    input  logic             pwr_on,
    input  logic             settled,
    input  logic [CH_W-1:0]  ctrl_chan,
    input  logic             core_done,
    input  logic [RES_W-1:0] core_data,
    output logic             core_start,
    output logic [CH_W-1:0]  core_sel,
    output logic             start_pend,
    output logic             busy,
    output logic             conv_flag,
    output logic [RES_W-1:0] result,
    output logic [CH_W-1:0]  samp_chan
);

    logic [CH_W-1:0] launch_chan;
    logic            launch;

    assign launch   = start_pend && pwr_on && settled && !busy;
    assign core_sel = busy ? launch_chan : ctrl_chan;

    always_ff @(posedge clk) begin
        if (rst) begin
            core_start  <= 1'b0;
            start_pend  <= 1'b0;
            busy        <= 1'b0;
            conv_flag   <= 1'b0;
            result      <= '0;
            samp_chan   <= '0;
            launch_chan <= '0;
        end else if (evt.pwr_off_wr) begin
            core_start <= 1'b0;
            start_pend <= 1'b0;
            busy       <= 1'b0;
            conv_flag  <= 1'b0;
        end else begin
            core_start <= launch;
            if (launch) begin
                busy        <= 1'b1;
                start_pend  <= 1'b0;
                launch_chan <= ctrl_chan;
            end
            if (busy && core_done) begin
                busy      <= 1'b0;
                conv_flag <= 1'b1;
                result    <= core_data;
                samp_chan <= launch_chan;
            end
            // a new request wins over a launch or completion in the same cycle
            if (evt.start_req) begin
                start_pend <= 1'b1;
                conv_flag  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/adc_regfront.sv
module adc_regfront
    import adc_regfront_pkg::*;
#(
    parameter int unsigned ADDR_W        = 8,
    parameter int unsigned BUS_W         = 32,
    parameter int unsigned CH_W          = 3,
    parameter int unsigned RES_W         = 10,
    parameter int unsigned SETTLE_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [CH_W-1:0]   core_sel,
    output logic              core_start,
    output logic              core_pwr,
    input  logic              core_done,
    input  logic [RES_W-1:0]  core_data
);

    wr_evt_t          evt;
    logic [CH_W-1:0]  wr_chan;
    logic             wr_single;
    logic [CH_W-1:0]  ctrl_chan_q;
    logic             ctrl_single_q;
    logic             pwr_q;
    logic             settled;
    logic             start_pend_w;
    logic             busy_w;
    logic             flag_w;
    logic [RES_W-1:0] result_w;
    logic [CH_W-1:0]  samp_w;

    adc_bus_port #(
        .ADDR_W(ADDR_W), .BUS_W(BUS_W), .CH_W(CH_W), .RES_W(RES_W)
    ) port_i (
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .evt        (evt),
        .wr_chan    (wr_chan),
        .wr_single  (wr_single),
        .ctrl_chan  (ctrl_chan_q),
        .ctrl_single(ctrl_single_q),
        .start_pend (start_pend_w),
        .result     (result_w),
        .conv_flag  (flag_w),
        .samp_chan  (samp_w),
        .pwr_on     (pwr_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_chan_q   <= '0;
            ctrl_single_q <= 1'b0;
            pwr_q         <= 1'b0;
        end else begin
            if (evt.ctrl_wr) begin
                ctrl_chan_q   <= wr_chan;
                ctrl_single_q <= wr_single;
            end
            if (evt.pwr_on_wr) begin
                pwr_q <= 1'b1;
            end else if (evt.pwr_off_wr) begin
                pwr_q <= 1'b0;
            end
        end
    end

    adc_settle_timer #(
        .SETTLE_CYCLES(SETTLE_CYCLES)
    ) settle_i (
        .clk    (clk),
        .rst    (rst),
        .pwr_on (pwr_q),
        .settled(settled)
    );

    adc_conv_seq #(
        .CH_W(CH_W), .RES_W(RES_W)
    ) seq_i (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .pwr_on    (pwr_q),
        .settled   (settled),
        .ctrl_chan (ctrl_chan_q),
        .core_done (core_done),
        .core_data (core_data),
        .core_start(core_start),
        .core_sel  (core_sel),
        .start_pend(start_pend_w),
        .busy      (busy_w),
        .conv_flag (flag_w),
        .result    (result_w),
        .samp_chan (samp_w)
    );

    assign core_pwr = pwr_q;

endmodule

// File: rtl/adc_regfront_chk.sv
module adc_regfront_chk #(
    parameter int unsigned SETTLE_CYCLES = 8
) (
    input logic clk,
    input logic rst,
    input logic core_pwr,
    input logic core_start,
    input logic core_done,
    input logic conv_flag,
    input logic busy
);

    localparam int unsigned AGE_W = $clog2(SETTLE_CYCLES + 2);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(SETTLE_CYCLES + 1);

    // edges seen with the core powered, saturating
    logic [AGE_W-1:0] pwr_age;

    always_ff @(posedge clk) begin
        if (rst || !core_pwr) begin
            pwr_age <= '0;
        end else if (pwr_age != AGE_MAX) begin
            pwr_age <= pwr_age + AGE_W'(1);
        end
    end

    AST_SETTLE_BEFORE_START: assert property (@(posedge clk) disable iff (rst)
        core_start |-> (pwr_age == AGE_MAX)) else $error("launch before settling"); // R4

    AST_START_NEEDS_POWER: assert property (@(posedge clk) disable iff (rst)
        core_start |-> core_pwr) else $error("launch while unpowered"); // R8

    AST_START_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        core_start |=> !core_start) else $error("start wider than one cycle"); // R5

    AST_FLAG_FROM_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_flag) |-> $past(core_done)) else $error("flag set without done"); // R6

    AST_POWERDOWN_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $fell(core_pwr) |-> (!conv_flag && !busy)) else $error("power-down left state"); // R8

endmodule

bind adc_regfront adc_regfront_chk #(
    .SETTLE_CYCLES(SETTLE_CYCLES)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .core_pwr  (core_pwr),
    .core_start(core_start),
    .core_done (core_done),
    .conv_flag (flag_w),
    .busy      (busy_w)
);

// File: tb/adc_core_stub.sv
module adc_core_stub #(
    parameter int unsigned CH_W    = 3,
    parameter int unsigned RES_W   = 10,
    parameter int unsigned LATENCY = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr,
    input  logic             start,
    input  logic [CH_W-1:0]  sel,
    output logic             done,
    output logic [RES_W-1:0] data
);

    int unsigned     cnt;
    logic [CH_W-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (rst || !pwr) begin
            cnt  <= 0;
            done <= 1'b0;
            data <= '0;
            sel_q <= '0;
        end else begin
            done <= 1'b0;
            if (start && cnt == 0) begin
                cnt   <= LATENCY;
                sel_q <= sel;
            end else if (cnt != 0) begin
                cnt <= cnt - 1;
                if (cnt == 1) begin
                    done <= 1'b1;
                    data <= RES_W'(32'(sel_q) * 146 + 1);
                end
            end
        end
    end

endmodule

// File: tb/adc_regfront_tb_top.sv
module adc_regfront_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int BUS_W  = 32;
    localparam int CH_W   = 3;
    localparam int RES_W  = 10;
    localparam int SETTLE = 8;
    localparam int LAT    = 12;

    localparam logic [7:0] A_CTRL = 8'h00, A_RES = 8'h04, A_FLAG = 8'h08,
                           A_SAMP = 8'h0C, A_PWR = 8'h10;

    // {channel, expected result}
    localparam logic [12:0] VEC [8] = '{
        {3'd3, 10'd439}, {3'd0, 10'd1},   {3'd7, 10'd1023}, {3'd5, 10'd731},
        {3'd1, 10'd147}, {3'd6, 10'd877}, {3'd2, 10'd293},  {3'd4, 10'd585}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [BUS_W-1:0]  bus_wdata = '0;
    logic [BUS_W-1:0]  bus_rdata;
    logic [CH_W-1:0]   core_sel;
    logic              core_start, core_pwr, core_done;
    logic [RES_W-1:0]  core_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int n_start = 0;
    int last_start_cyc = -1;
    logic [CH_W-1:0] last_sel = '0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    adc_regfront #(
        .ADDR_W(ADDR_W), .BUS_W(BUS_W), .CH_W(CH_W), .RES_W(RES_W), .SETTLE_CYCLES(SETTLE)
    ) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .core_sel(core_sel), .core_start(core_start),
        .core_pwr(core_pwr), .core_done(core_done), .core_data(core_data)
    );

    adc_core_stub #(.CH_W(CH_W), .RES_W(RES_W), .LATENCY(LAT)) stub_i (
        .clk(clk), .rst(rst), .pwr(core_pwr), .start(core_start), .sel(core_sel),
        .done(core_done), .data(core_data)
    );

    always @(negedge clk) begin
        if (!rst && core_start) begin
            n_start++;
            last_start_cyc = cyc;
            last_sel = core_sel;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        #1;
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_flag(output bit ok);
        logic [31:0] v;
        ok = 0;
        for (int i = 0; i < 100; i++) begin
            bus_rd(A_FLAG, v);
            if (v[0]) begin
                ok = 1;
                break;
            end
        end
    endtask

    task automatic wait_start(input int prev, output bit ok);
        ok = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            #2;
            if (n_start > prev) begin
                ok = 1;
                break;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] res_prev;
        bit ok;
        int p0, prev;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        bus_rd(A_CTRL, v); chk("R1", "ctrl after reset", v, 32'h0);
        bus_rd(A_RES,  v); chk("R1", "result after reset", v, 32'h0);
        bus_rd(A_FLAG, v); chk("R1", "flag after reset", v, 32'h0);
        bus_rd(A_SAMP, v); chk("R1", "sampled after reset", v, 32'h0);
        bus_rd(A_PWR,  v); chk("R1", "power after reset", v, 32'h0);
        chk("R1", "core_pwr after reset", 32'(core_pwr), 32'h0);
        chk("R1", "core_start after reset", 32'(core_start), 32'h0);

        // R2: start written while unpowered is held; mode bit reads back
        prev = n_start;
        bus_wr(A_CTRL, 32'h0000_0034);
        wait_cyc(20);
        chk("R8", "no launch while unpowered", n_start, prev);
        bus_rd(A_CTRL, v); chk("R2", "ctrl readback pending", v, 32'h0000_0034);
        bus_wr(A_CTRL, 32'h0000_0024);
        bus_rd(A_CTRL, v); chk("R2", "bit4 clear keeps pending", v, 32'h0000_0034);

        // R3/R4: power up, measure the launch cycle
        bus_wr(A_PWR, 32'h1);
        p0 = cyc;
        chk("R3", "core_pwr follows register", 32'(core_pwr), 32'h1);
        bus_rd(A_PWR, v); chk("R3", "power readback", v, 32'h1);
        wait_start(prev, ok);
        chk("R4", "launch seen", 32'(ok), 32'h1);
        chk("R4", "launch cycle after power write", last_start_cyc - p0, SETTLE + 1);
        chk("R5", "core_sel at launch", 32'(last_sel), 32'h4);
        wait_flag(ok);
        chk("R6", "flag after first conversion", 32'(ok), 32'h1);
        chk("R5", "single pulse per conversion", n_start - prev, 1);
        bus_rd(A_RES, v);  chk("R6", "first result", v, 32'd585);
        bus_rd(A_CTRL, v); chk("R5", "start bit self-cleared", v, 32'h0000_0024);

        // vector table walk: R5 R6 R7
        foreach (VEC[i]) begin
            logic [2:0] ch;
            logic [9:0] ex;
            ch = VEC[i][12:10];
            ex = VEC[i][9:0];
            prev = n_start;
            bus_wr(A_CTRL, 32'h10 | 32'(ch));
            bus_rd(A_FLAG, v); chk("R6", "flag cleared by start", v, 32'h0);
            wait_flag(ok);
            chk("R6", "flag set on completion", 32'(ok), 32'h1);
            chk("R5", "core_sel carried channel", 32'(last_sel), 32'(ch));
            chk("R5", "exactly one pulse", n_start - prev, 1);
            bus_rd(A_RES, v);  chk("R6", "result value", v, 32'(ex));
            bus_rd(A_SAMP, v); chk("R7", "sampled channel", v, 32'(ch));
            bus_rd(A_CTRL, v); chk("R5", "start bit cleared", v, 32'(ch));
        end

        // R6: full-scale result, upper bits zero
        bus_wr(A_CTRL, 32'h17);
        wait_flag(ok);
        bus_rd(A_RES, v); chk("R6", "full-scale result, upper bits zero", v, 32'h0000_03FF);

        // R7: rewrite channel mid-conversion
        prev = n_start;
        bus_wr(A_CTRL, 32'h12);
        wait_start(prev, ok);
        bus_wr(A_CTRL, 32'h05);
        wait_flag(ok);
        chk("R7", "conversion completed", 32'(ok), 32'h1);
        bus_rd(A_SAMP, v); chk("R7", "sampled keeps launched channel", v, 32'h2);
        bus_rd(A_CTRL, v); chk("R7", "ctrl holds new channel", v, 32'h5);
        bus_rd(A_RES, v);  chk("R7", "result of launched channel", v, 32'd293);
        res_prev = v;

        // R8: power down mid-conversion
        prev = n_start;
        bus_wr(A_CTRL, 32'h11);
        wait_start(prev, ok);
        bus_wr(A_PWR, 32'h0);
        chk("R8", "core_pwr low", 32'(core_pwr), 32'h0);
        wait_cyc(LAT + 10);
        bus_rd(A_FLAG, v); chk("R8", "flag stays clear after abort", v, 32'h0);
        bus_rd(A_RES, v);  chk("R8", "result unchanged after abort", v, res_prev);
        bus_wr(A_CTRL, 32'h06);
        wait_cyc(3);
        bus_wr(A_CTRL, 32'h16);
        wait_cyc(15);
        bus_rd(A_CTRL, v); chk("R8", "pending start kept while unpowered", v, 32'h16);
        prev = n_start;
        bus_wr(A_PWR, 32'h1);
        p0 = cyc;
        wait_start(prev, ok);
        chk("R8", "settling restarted after power-down", last_start_cyc - p0, SETTLE + 1);
        wait_flag(ok);
        bus_rd(A_RES, v); chk("R8", "conversion after re-power", v, 32'd877);

        // R8: power-down clears a pending start
        bus_wr(A_PWR, 32'h0);
        bus_wr(A_CTRL, 32'h13);
        bus_wr(A_PWR, 32'h0);
        bus_rd(A_CTRL, v); chk("R8", "power-down drops pending start", v, 32'h3);

        // R9: unmapped offsets
        bus_wr(A_PWR, 32'h1);
        bus_wr(A_CTRL, 32'h21);
        bus_wr(8'h14, 32'hFFFF_FFFF);
        bus_wr(8'h20, 32'hFFFF_FFFF);
        bus_wr(8'h3C, 32'h0000_0000);
        bus_rd(8'h14, v); chk("R9", "offset 0x14 reads zero", v, 32'h0);
        bus_rd(8'h20, v); chk("R9", "offset 0x20 reads zero", v, 32'h0);
        bus_rd(8'h18, v); chk("R9", "offset 0x18 reads zero", v, 32'h0);
        bus_rd(A_CTRL, v); chk("R9", "ctrl untouched by stray writes", v, 32'h21);
        bus_rd(A_PWR, v);  chk("R9", "power untouched by stray writes", v, 32'h1);
        chk("R9", "core_pwr untouched", 32'(core_pwr), 32'h1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule